// File: doc/BRIEF.md
# Register-Mapped Pseudo-Random Number Peripheral

This block is a 32-bit pseudo-random number source built around a file of 64 words, each 32 bits wide. A bus master can reach the words in two ways. The direct request channel carries a byte address, and the word index is that address shifted right by two. The indirect channel has two slots. The address slot holds a byte address. The data slot reads or writes the word that the stored address points to.

Most words store whatever is written to them. A few word indices have side effects instead. Word 0 reseeds a generator whose state cannot be read. Word 1 advances that generator and holds its newest output. Word 3 advances a second generator whose state lives openly in word 2. Both generators use the same linear congruential step.

Both request channels use valid/ready. The direct channel is always ready. The indirect channel is held off, with ready low, in any cycle in which the direct channel presents a request. A master that sees ready low must keep its request and its fields stable until ready returns. Every read produces one response pulse, with its data, in the cycle after the read is accepted. Responses cannot be stalled.

Top module: `prng_regport`

## Requirements
- R1: On the direct channel, a read of byte address A with size 4 and A[1:0]=0 returns word A>>2. A write with the same checks updates that word, subject to R3 to R5.
- R2: A direct access whose size field is not 4 or whose byte address has A[1:0]≠0 is rejected. A rejected read returns 0xFFFFFFFF. A rejected write changes no word and no generator state.
- R3: An accepted write to word 0 loads the written value into the hidden generator state. Word 0 is never stored and always reads 0.
- R4: An accepted write to word 1 steps the hidden state once and stores the step's output in word 1. The write data is ignored.
- R5: An accepted write to word 3 steps word 2 once. The new state goes into word 2 and the step's output goes into word 3. The write data is ignored.
- R6: An accepted write to any word other than 0, 1 and 3 stores the written data unchanged.
- R7: One step computes S' = S·1103515245 + 12345 mod 2^32. The output is S'[30:16], zero-extended to 32 bits.
- R8: On the indirect channel, offset 0 writes or reads the stored address. Offset 4 is the data window. Only size-4 accesses are accepted. Any other size, or any offset other than 0 or 4, is rejected: a read returns 0xFFFFFFFF and a write has no effect.
- R9: A data-window access is rejected when the stored address has bits [1:0]≠0 or selects word index 64 or above. A rejected read returns 0xFFFFFFFF and a rejected write has no effect. An accepted window access acts exactly like a direct access to word address>>2.
- R10: The direct ready is always 1. The indirect ready is 0 in any cycle in which the direct valid is 1. Each accepted write applies its side effect exactly once.
- R11: After reset every word reads 0, the stored address reads 0 and the hidden state is 1.
- R12: The rvalid of a channel is high for exactly one cycle, the cycle after that channel accepts a read, and the read data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_valid | input | 1 | Direct request valid |
| d_ready | output | 1 | Direct request ready (always 1) |
| d_write | input | 1 | Direct request is a write |
| d_addr | input | 8 | Direct byte address |
| d_size | input | 3 | Direct access size in bytes |
| d_wdata | input | 32 | Direct write data |
| d_rvalid | output | 1 | Direct read response valid |
| d_rdata | output | 32 | Direct read response data |
| p_valid | input | 1 | Indirect request valid |
| p_ready | output | 1 | Indirect request ready |
| p_write | input | 1 | Indirect request is a write |
| p_off | input | 3 | Indirect slot offset (0 address, 4 data) |
| p_size | input | 3 | Indirect access size in bytes |
| p_wdata | input | 32 | Indirect write data |
| p_rvalid | output | 1 | Indirect read response valid |
| p_rdata | output | 32 | Indirect read response data |

## Verification
A read response, with its data, appears one clock edge after the edge that accepts the read. A write's effect becomes visible to any read accepted at the next edge or later. The bench drives every request on a falling edge. It samples responses at the following falling edge, which lies half a period after the accepting edge. This puts every check exactly one register stage after its stimulus. The ready of the indirect channel depends combinationally on the direct valid, so the bench checks it a short delay after the request is driven, within the same cycle.

// File: rtl/prng_regport_pkg.sv
package prng_regport_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam logic [31:0] LCG_MUL = 32'd1103515245;
  localparam logic [31:0] LCG_INC = 32'd12345;
  localparam int unsigned IDX_SEED    = 0;
  localparam int unsigned IDX_HID_OUT = 1;
  localparam int unsigned IDX_VIS_ST  = 2;
  localparam int unsigned IDX_VIS_OUT = 3;
  localparam logic [2:0]  SIZE_WORD   = 3'd4;

  function automatic logic [31:0] lcg_next(input logic [31:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction

  function automatic logic [31:0] lcg_out(input logic [31:0] s);
    return {17'd0, s[30:16]};
  endfunction
endpackage

// File: rtl/prng_access_front.sv
module prng_access_front
  import prng_regport_pkg::*;
#(
  parameter int unsigned NW = 64,
  localparam int unsigned IW = $clog2(NW),
  localparam int unsigned AW = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  output logic              d_ready,
  input  logic              d_write,
  input  logic [AW-1:0]     d_addr,
  input  logic [2:0]        d_size,
  input  logic [WORD_W-1:0] d_wdata,
  output logic              d_rvalid,
  output logic [WORD_W-1:0] d_rdata,
  input  logic              p_valid,
  output logic              p_ready,
  input  logic              p_write,
  input  logic [2:0]        p_off,
  input  logic [2:0]        p_size,
  input  logic [WORD_W-1:0] p_wdata,
  output logic              p_rvalid,
  output logic [WORD_W-1:0] p_rdata,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic [IW-1:0]     rd_idx,
  input  logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] ind_addr;
  logic d_ok, p_fire, p_szok, p_is_addr, p_is_win, win_ok;
  logic d_wr_go, p_wr_go;

  assign d_ready   = 1'b1;
  assign p_ready   = ~d_valid;
  assign d_ok      = (d_size == SIZE_WORD) && (d_addr[1:0] == 2'b00);
  assign p_fire    = p_valid && p_ready;
  assign p_szok    = (p_size == SIZE_WORD);
  assign p_is_addr = p_szok && (p_off == 3'd0);
  assign p_is_win  = p_szok && (p_off == 3'd4);
  assign win_ok    = (ind_addr[1:0] == 2'b00) && ((ind_addr >> AW) == '0);

  assign d_wr_go = d_valid && d_write && d_ok;
  assign p_wr_go = p_fire && p_write && p_is_win && win_ok;

  always_comb begin
    wr_en   = d_wr_go || p_wr_go;
    wr_idx  = d_wr_go ? d_addr[AW-1:2] : ind_addr[AW-1:2];
    wr_data = d_wr_go ? d_wdata : p_wdata;
    rd_idx  = d_valid ? d_addr[AW-1:2] : ind_addr[AW-1:2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ind_addr <= '0;
      d_rvalid <= 1'b0;
      d_rdata  <= '0;
      p_rvalid <= 1'b0;
      p_rdata  <= '0;
    end else begin
      d_rvalid <= d_valid && !d_write;
      p_rvalid <= p_fire && !p_write;
      if (d_valid && !d_write)
        d_rdata <= d_ok ? rd_word : '1;
      if (p_fire && !p_write) begin
        if (p_is_addr)                p_rdata <= ind_addr;
        else if (p_is_win && win_ok)  p_rdata <= rd_word;
        else                          p_rdata <= '1;
      end
      if (p_fire && p_write && p_is_addr)
        ind_addr <= p_wdata;
    end
  end

  a_r2_reject_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_write && (d_size != SIZE_WORD)) |=> (d_rvalid && d_rdata == '1));
  a_r9_window_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !d_valid && !p_write && p_is_win && ind_addr[1:0] != 2'b00)
      |=> (p_rvalid && p_rdata == '1));
  a_r10_blocked_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && p_valid && !p_write) |=> !p_rvalid);
  a_r12_resp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    d_rvalid |-> $past(d_valid && !d_write));
endmodule

// File: rtl/prng_word_store.sv
module prng_word_store
  import prng_regport_pkg::*;
#(
  parameter int unsigned NW = 64,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] words [NW];
  logic [WORD_W-1:0] hid_q, hid_nx, vis_nx;

  assign hid_nx = lcg_next(hid_q);
  assign vis_nx = lcg_next(words[IDX_VIS_ST]);

  always_ff @(posedge clk) begin
    if (!rst_n)                                   hid_q <= 32'd1;
    else if (wr_en && wr_idx == IW'(IDX_SEED))    hid_q <= wr_data;
    else if (wr_en && wr_idx == IW'(IDX_HID_OUT)) hid_q <= hid_nx;
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    if (g == IDX_SEED) begin : g_seed
      assign words[g] = '0;
    end else if (g == IDX_HID_OUT) begin : g_hout
      always_ff @(posedge clk)
        if (!rst_n)                                words[g] <= '0;
        else if (wr_en && wr_idx == IW'(g))        words[g] <= lcg_out(hid_nx);
    end else if (g == IDX_VIS_ST) begin : g_vst
      always_ff @(posedge clk)
        if (!rst_n)                                words[g] <= '0;
        else if (wr_en && wr_idx == IW'(IDX_VIS_OUT)) words[g] <= vis_nx;
        else if (wr_en && wr_idx == IW'(g))        words[g] <= wr_data;
    end else if (g == IDX_VIS_OUT) begin : g_vout
      always_ff @(posedge clk)
        if (!rst_n)                                words[g] <= '0;
        else if (wr_en && wr_idx == IW'(g))        words[g] <= lcg_out(vis_nx);
    end else begin : g_plain
      always_ff @(posedge clk)
        if (!rst_n)                                words[g] <= '0;
        else if (wr_en && wr_idx == IW'(g))        words[g] <= wr_data;
    end
  end

  assign rd_word = words[rd_idx];

  a_r3_seed_keeps_out: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(IDX_SEED)) |=> $stable(words[IDX_HID_OUT]));
  a_r4_hidden_out: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(IDX_HID_OUT)) |=> (words[IDX_HID_OUT] == {17'd0, hid_q[30:16]}));
  a_r5_visible_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IW'(IDX_VIS_OUT)) |=>
      (words[IDX_VIS_ST] == $past(words[IDX_VIS_ST]) * LCG_MUL + LCG_INC &&
       words[IDX_VIS_OUT] == {17'd0, words[IDX_VIS_ST][30:16]}));
endmodule

// File: rtl/prng_regport.sv
module prng_regport
  import prng_regport_pkg::*;
#(
  parameter int unsigned NW = 64,
  localparam int unsigned IW = $clog2(NW),
  localparam int unsigned AW = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  output logic              d_ready,
  input  logic              d_write,
  input  logic [AW-1:0]     d_addr,
  input  logic [2:0]        d_size,
  input  logic [WORD_W-1:0] d_wdata,
  output logic              d_rvalid,
  output logic [WORD_W-1:0] d_rdata,
  input  logic              p_valid,
  output logic              p_ready,
  input  logic              p_write,
  input  logic [2:0]        p_off,
  input  logic [2:0]        p_size,
  input  logic [WORD_W-1:0] p_wdata,
  output logic              p_rvalid,
  output logic [WORD_W-1:0] p_rdata
);
  logic              wr_en;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [WORD_W-1:0] wr_data, rd_word;

  prng_access_front #(.NW(NW)) front_i (
    .clk(clk), .rst_n(rst_n),
    .d_valid(d_valid), .d_ready(d_ready), .d_write(d_write), .d_addr(d_addr),
    .d_size(d_size), .d_wdata(d_wdata), .d_rvalid(d_rvalid), .d_rdata(d_rdata),
    .p_valid(p_valid), .p_ready(p_ready), .p_write(p_write), .p_off(p_off),
    .p_size(p_size), .p_wdata(p_wdata), .p_rvalid(p_rvalid), .p_rdata(p_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  prng_word_store #(.NW(NW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );
endmodule

// File: tb/prng_regport_tb_top.sv
module prng_regport_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic rst_n;
  logic d_valid, d_ready, d_write, d_rvalid, p_valid, p_ready, p_write, p_rvalid;
  logic [7:0]  d_addr;
  logic [2:0]  d_size, p_off, p_size;
  logic [31:0] d_wdata, d_rdata, p_wdata, p_rdata;
  int n_run = 0, n_fail = 0;
  logic [31:0] hid = 32'd1;

  always #(CLK_PERIOD/2) clk = ~clk;

  prng_regport dut_i (.*);

  function automatic logic [31:0] step(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction
  function automatic logic [31:0] outv(input logic [31:0] s);
    return {17'd0, s[30:16]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dwr(input logic [7:0] a, input logic [31:0] v, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    d_valid = 1; d_write = 1; d_addr = a; d_wdata = v; d_size = sz;
    @(negedge clk);
    d_valid = 0; d_write = 0;
  endtask

  task automatic drd(input logic [7:0] a, output logic [31:0] v, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    d_valid = 1; d_write = 0; d_addr = a; d_size = sz;
    @(negedge clk);
    d_valid = 0;
    chk("R12 d_rvalid", {31'd0, d_rvalid}, 32'd1);
    v = d_rdata;
  endtask

  task automatic pwr(input logic [2:0] o, input logic [31:0] v, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    p_valid = 1; p_write = 1; p_off = o; p_wdata = v; p_size = sz;
    @(negedge clk);
    p_valid = 0; p_write = 0;
  endtask

  task automatic prd(input logic [2:0] o, output logic [31:0] v, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    p_valid = 1; p_write = 0; p_off = o; p_size = sz;
    @(negedge clk);
    p_valid = 0;
    chk("R12 p_rvalid", {31'd0, p_rvalid}, 32'd1);
    v = p_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      drd(8'(i * 4), v);
      chk("R11 word after reset", v, 32'd0);
    end
    prd(3'd0, v);
    chk("R11 stored address after reset", v, 32'd0);
    @(negedge clk);
    chk("R12 rvalid one cycle only", {31'd0, d_rvalid}, 32'd0);
    chk("R10 d_ready", {31'd0, d_ready}, 32'd1);
  endtask

  task automatic t_hidden();
    logic [31:0] v;
    dwr(8'd4, 32'hDEAD_BEEF);
    hid = step(hid);
    drd(8'd4, v);
    chk("R11 R4 R7 first step from state 1", v, outv(hid));
    chk("R7 known first output", v, 32'd16838);
    dwr(8'd0, 32'd1234);
    hid = 32'd1234;
    drd(8'd0, v);
    chk("R3 word 0 reads zero", v, 32'd0);
    drd(8'd4, v);
    chk("R3 seed leaves word 1", v, 32'd16838);
    for (int k = 0; k < 3; k++) begin
      dwr(8'd4, 32'(k));
      hid = step(hid);
      drd(8'd4, v);
      chk("R4 hidden step", v, outv(hid));
    end
  endtask

  task automatic t_chain();
    logic [31:0] v, s;
    s = 32'hCAFE_0001;
    dwr(8'd8, s);
    for (int k = 0; k < 3; k++) begin
      dwr(8'd12, 32'hFFFF_FFFF);
      s = step(s);
      drd(8'd12, v);
      chk("R5 visible output", v, outv(s));
      drd(8'd8, v);
      chk("R5 visible state", v, s);
    end
  endtask

  task automatic t_plain();
    logic [31:0] v;
    dwr(8'd20, 32'hA5A5_0F0F);
    drd(8'd20, v);
    chk("R6 R1 plain store word 5", v, 32'hA5A5_0F0F);
    dwr(8'd252, 32'h1234_5678);
    drd(8'd252, v);
    chk("R6 R1 plain store word 63", v, 32'h1234_5678);
  endtask

  task automatic t_direct_reject();
    logic [31:0] v;
    drd(8'd22, v);
    chk("R2 misaligned read", v, 32'hFFFF_FFFF);
    drd(8'd20, v, 3'd2);
    chk("R2 short read", v, 32'hFFFF_FFFF);
    dwr(8'd21, 32'h0000_0001);
    dwr(8'd20, 32'h0000_0002, 3'd1);
    drd(8'd20, v);
    chk("R2 rejected writes ignored", v, 32'hA5A5_0F0F);
    dwr(8'd1, 32'h0000_0077);
    dwr(8'd4, 32'd0);
    hid = step(hid);
    drd(8'd4, v);
    chk("R2 rejected seed ignored", v, outv(hid));
  endtask

  task automatic t_port();
    logic [31:0] v;
    pwr(3'd0, 32'd40);
    prd(3'd0, v);
    chk("R8 address slot", v, 32'd40);
    pwr(3'd4, 32'h0BAD_F00D);
    drd(8'd40, v);
    chk("R8 window write", v, 32'h0BAD_F00D);
    prd(3'd4, v);
    chk("R8 window read", v, 32'h0BAD_F00D);
    pwr(3'd0, 32'd99, 3'd2);
    prd(3'd0, v);
    chk("R8 short address write ignored", v, 32'd40);
    prd(3'd2, v);
    chk("R8 bad offset read", v, 32'hFFFF_FFFF);
    prd(3'd4, v, 3'd1);
    chk("R8 short window read", v, 32'hFFFF_FFFF);
    pwr(3'd0, 32'd4);
    pwr(3'd4, 32'h5555_5555);
    hid = step(hid);
    prd(3'd4, v);
    chk("R9 window step acts like direct", v, outv(hid));
  endtask

  task automatic t_port_reject();
    logic [31:0] v;
    pwr(3'd0, 32'd42);
    prd(3'd4, v);
    chk("R9 misaligned window read", v, 32'hFFFF_FFFF);
    pwr(3'd4, 32'h1111_1111);
    pwr(3'd0, 32'd40);
    prd(3'd4, v);
    chk("R9 misaligned window write ignored", v, 32'h0BAD_F00D);
    pwr(3'd0, 32'd256);
    prd(3'd4, v);
    chk("R9 out of range read", v, 32'hFFFF_FFFF);
    pwr(3'd4, 32'h0000_0009);
    pwr(3'd0, 32'd260);
    pwr(3'd4, 32'h0000_0009);
    dwr(8'd4, 32'd0);
    hid = step(hid);
    drd(8'd4, v);
    chk("R9 out of range writes ignored", v, outv(hid));
  endtask

  task automatic t_prio();
    logic [31:0] v;
    pwr(3'd0, 32'd4);
    @(negedge clk);
    d_valid = 1; d_write = 1; d_addr = 8'd44; d_wdata = 32'h7777_0000; d_size = 3'd4;
    p_valid = 1; p_write = 1; p_off = 3'd4; p_wdata = 32'h0; p_size = 3'd4;
    #1 chk("R10 port held off", {31'd0, p_ready}, 32'd0);
    @(negedge clk);
    d_valid = 0; d_write = 0;
    #1 chk("R10 port ready again", {31'd0, p_ready}, 32'd1);
    @(negedge clk);
    p_valid = 0; p_write = 0;
    hid = step(hid);
    drd(8'd44, v);
    chk("R10 direct write applied", v, 32'h7777_0000);
    drd(8'd4, v);
    chk("R10 single step for held write", v, outv(hid));
  endtask

  initial begin
    rst_n = 0;
    d_valid = 0; d_write = 0; d_addr = 0; d_size = 0; d_wdata = 0;
    p_valid = 0; p_write = 0; p_off = 0; p_size = 0; p_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hidden();
    t_chain();
    t_plain();
    t_direct_reject();
    t_port();
    t_port_reject();
    t_prio();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule